// File: doc/BRIEF.md
# Octant-Folded Twiddle Factor Generator

This block supplies the complex rotation factor W = e^(-j*2*pi*k/N) that a radix-2 FFT butterfly multiplies by. The requester raises a strobe with an index k in the range 0 to N/2-1. One clock later the block presents the real and imaginary parts as signed fixed-point words, together with a valid flag. The default transform size is N = 1024, so 512 factors are reachable.

The read-only table holds only the first eighth of the unit circle: the cosine and sine of 2*pi*m/N for m = 0..N/8, which is 129 entries by default. Three steps rebuild every other factor. First, the upper half of the index range is folded down by a quarter turn. Second, indices past the first eighth are mirrored around the eighth-circle point, with cosine and sine exchanged. Third, the correct signs are applied. The table contents are computed when the design is elaborated. Any bit column that has the same value in every stored word is tied to that constant, so it takes no storage.

Top module: `twiddle_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset is released, `tw_valid_o` is 0 and both `tw_re_o` and `tw_im_o` are 0.
- R2: `tw_valid_o` is 1 in exactly the cycles that directly follow a cycle with `req_valid_i` = 1.
- R3: The output format is two's complement on W bits with W-2 fractional bits, so 1.0 is 2^(W-2). For k in 0..N/8, `tw_re_o` is within 1 LSB of round(cos(2*pi*k/N)*2^(W-2)) and `tw_im_o` is within 1 LSB of round(-sin(2*pi*k/N)*2^(W-2)).
- R4: The same 1 LSB accuracy holds for k in N/8+1..N/4-1. For such k, the factor is the exact mirror of the factor at N/4-k: the real part of k equals minus the imaginary part of N/4-k, and the imaginary part of k equals minus the real part of N/4-k.
- R5: The same 1 LSB accuracy holds for k in N/4..N/2-1. For such k, the factor is the quarter-turn rotation of the factor at k-N/4: the real part of k equals the imaginary part of k-N/4, and the imaginary part of k equals minus the real part of k-N/4.
- R6: Three values are exact. Index 0 gives (2^(W-2), 0). Index N/4 gives (0, -2^(W-2)). At index N/8, the real part equals minus the imaginary part.
- R7: In a cycle after `req_valid_i` = 0, `tw_re_o` and `tw_im_o` keep their previous values, whatever `req_idx_i` holds.
- R8: The imaginary output is never positive. The real output is not negative for k < N/4 and not positive for k > N/4.
- R9: A new request is accepted every cycle. Back-to-back requests and requests separated by idle cycles each return the factor for their own index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_idx_i | input | LOG2N-1 | Index k of the requested factor |
| tw_valid_o | output | 1 | Result valid, one cycle after the request |
| tw_re_o | output | W | Real part, signed, W-2 fractional bits |
| tw_im_o | output | W | Imaginary part, signed, W-2 fractional bits |

## Verification
Several rules are checked by assertions on every cycle: the one-cycle valid relation, holding the outputs when idle, the exact values at index 0 and N/4, the sign of the imaginary part and of the real part, and the range of the mirrored table address. Only the bench scenarios can show numeric accuracy against the true trigonometric values and the exact mirror and rotation relations between pairs of indices. The bench sweeps all N/2 indices and compares each one against cosine and sine computed in the bench. It also replays a gapped, out-of-order sequence of indices to show that results do not depend on request history.

// File: rtl/twg_pkg.sv
package twg_pkg;

   localparam real PI_C = 3.14159265358979323846;

   // fold controls derived from the request index
   typedef struct packed {
      logic mirror;   // index lies past the eighth-circle point
      logic rotate;   // index lies in the upper quarter pair
   } twg_fold_t;

   function automatic real series_cos(real x);
      real sum  = 1.0;
      real term = 1.0;
      for (int i = 1; i <= 14; i++) begin
         term = -term * x * x / (real'(2 * i - 1) * real'(2 * i));
         sum  = sum + term;
      end
      return sum;
   endfunction

   function automatic real series_sin(real x);
      real sum  = x;
      real term = x;
      for (int i = 1; i <= 14; i++) begin
         term = -term * x * x / (real'(2 * i) * real'(2 * i + 1));
         sum  = sum + term;
      end
      return sum;
   endfunction

   function automatic longint quantize(real v, int frac);
      real s = v;
      for (int i = 0; i < frac; i++) s = s * 2.0;
      return longint'(s);   // real-to-integer cast rounds to nearest
   endfunction

   // cosine (want_sin = 0) or sine (want_sin = 1) of 2*pi*m/2^log2n
   function automatic longint octant_val(int m, int log2n, int frac, bit want_sin);
      real n_r = 1.0;
      real ang;
      for (int i = 0; i < log2n; i++) n_r = n_r * 2.0;
      ang = 2.0 * PI_C * real'(m) / n_r;
      if (want_sin) return quantize(series_sin(ang), frac);
      return quantize(series_cos(ang), frac);
   endfunction

endpackage

// File: rtl/twg_fold.sv
module twg_fold
   import twg_pkg::*;
#(
   parameter int LOG2N = 10,
   parameter int IDXW  = LOG2N - 1,
   parameter int ADDRW = LOG2N - 2
) (
   input  logic [IDXW-1:0]  idx_i,
   output logic [ADDRW-1:0] addr_o,
   output twg_fold_t        fold_o
);

   localparam logic [ADDRW-1:0] OCT_POINT = ADDRW'(1 << (LOG2N - 3));

   logic [ADDRW-1:0] quarter_idx;

   if (IDXW != ADDRW + 1) begin : g_width_chk
      $error("twg_fold: index width must exceed address width by one");
   end

   // position within the quarter circle once the upper half is folded down
   assign quarter_idx   = idx_i[IDXW-2:0];
   assign fold_o.rotate = idx_i[IDXW-1];
   assign fold_o.mirror = (quarter_idx > OCT_POINT);

   // N/4 - q reduces to the two's complement of q on ADDRW bits
   assign addr_o = fold_o.mirror ? (~quarter_idx + 1'b1) : quarter_idx;

endmodule

// File: rtl/twg_octant_rom.sv
module twg_octant_rom
   import twg_pkg::*;
#(
   parameter int LOG2N = 10,
   parameter int W     = 32,
   parameter int ADDRW = LOG2N - 2
) (
   input  logic [ADDRW-1:0]    addr_i,
   output logic signed [W-1:0] cos_o,
   output logic signed [W-1:0] sin_o
);

   localparam int DEPTH = (1 << LOG2N) / 8 + 1;
   localparam int FRAC  = W - 2;
   localparam int WORDW = 2 * W;

   // one bit column across all stored words; upper half holds cosine
   function automatic logic [DEPTH-1:0] column(int b);
      logic [DEPTH-1:0] col;
      longint v;
      for (int m = 0; m < DEPTH; m++) begin
         if (b >= W) begin
            v      = octant_val(m, LOG2N, FRAC, 1'b0);
            col[m] = v[b - W];
         end else begin
            v      = octant_val(m, LOG2N, FRAC, 1'b1);
            col[m] = v[b];
         end
      end
      return col;
   endfunction

   function automatic int count_stored();
      int n = 0;
      logic [DEPTH-1:0] c;
      for (int b = 0; b < WORDW; b++) begin
         c = column(b);
         if ((c != '0) && (c != '1)) n++;
      end
      return n;
   endfunction

   localparam int STORED_BITS = count_stored();

   if (DEPTH > (1 << ADDRW)) begin : g_depth_chk
      $error("twg_octant_rom: address too narrow for table depth");
   end
   if (STORED_BITS >= WORDW) begin : g_pack_chk
      $error("twg_octant_rom: no constant column found, sign bits must be fixed");
   end

   logic [WORDW-1:0] word;

   for (genvar b = 0; b < WORDW; b++) begin : g_col
      localparam logic [DEPTH-1:0] COL = column(b);
      if (COL == '0) begin : g_tie0
         assign word[b] = 1'b0;
      end else if (COL == '1) begin : g_tie1
         assign word[b] = 1'b1;
      end else begin : g_stored
         assign word[b] = COL[addr_i];
      end
   end

   assign cos_o = word[WORDW-1:W];
   assign sin_o = word[W-1:0];

endmodule

// File: rtl/twg_rebuild.sv
module twg_rebuild
   import twg_pkg::*;
#(
   parameter int W = 32
) (
   input  logic signed [W-1:0] cos_i,
   input  logic signed [W-1:0] sin_i,
   input  twg_fold_t           fold_i,
   output logic signed [W-1:0] re_o,
   output logic signed [W-1:0] im_o
);

   logic signed [W-1:0] lo_re;
   logic signed [W-1:0] lo_im;

   // lower quarter: direct octant or mirrored octant (swap parts)
   always_comb begin
      if (fold_i.mirror) begin
         lo_re = sin_i;
         lo_im = -cos_i;
      end else begin
         lo_re = cos_i;
         lo_im = -sin_i;
      end
   end

   // upper quarter: multiply by -j
   always_comb begin
      if (fold_i.rotate) begin
         re_o = lo_im;
         im_o = -lo_re;
      end else begin
         re_o = lo_re;
         im_o = lo_im;
      end
   end

endmodule

// File: rtl/twiddle_gen.sv
module twiddle_gen
   import twg_pkg::*;
#(
   parameter int LOG2N = 10,
   parameter int W     = 32,
   localparam int IDXW  = LOG2N - 1,
   localparam int ADDRW = LOG2N - 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid_i,
   input  logic [IDXW-1:0]     req_idx_i,
   output logic                tw_valid_o,
   output logic signed [W-1:0] tw_re_o,
   output logic signed [W-1:0] tw_im_o
);

   localparam logic [IDXW-1:0]     QUARTER   = IDXW'(1 << (LOG2N - 2));
   localparam logic [ADDRW-1:0]    OCT_POINT = ADDRW'(1 << (LOG2N - 3));
   localparam logic signed [W-1:0] ONE       = {2'b01, {(W-2){1'b0}}};
   localparam logic signed [W-1:0] NEG_ONE   = {2'b11, {(W-2){1'b0}}};

   if (LOG2N < 4 || LOG2N > 16) begin : g_size_chk
      $error("twiddle_gen: LOG2N must lie in 4..16");
   end
   if (W < 8 || W > 40) begin : g_width_chk
      $error("twiddle_gen: W must lie in 8..40");
   end

   logic [ADDRW-1:0]    oct_addr;
   twg_fold_t           fold;
   logic signed [W-1:0] oct_cos;
   logic signed [W-1:0] oct_sin;
   logic signed [W-1:0] nxt_re;
   logic signed [W-1:0] nxt_im;

   twg_fold #(.LOG2N(LOG2N), .IDXW(IDXW), .ADDRW(ADDRW)) i_fold (
      .idx_i  (req_idx_i),
      .addr_o (oct_addr),
      .fold_o (fold)
   );

   twg_octant_rom #(.LOG2N(LOG2N), .W(W), .ADDRW(ADDRW)) i_rom (
      .addr_i (oct_addr),
      .cos_o  (oct_cos),
      .sin_o  (oct_sin)
   );

   twg_rebuild #(.W(W)) i_rebuild (
      .cos_i  (oct_cos),
      .sin_i  (oct_sin),
      .fold_i (fold),
      .re_o   (nxt_re),
      .im_o   (nxt_im)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tw_valid_o <= 1'b0;
         tw_re_o    <= '0;
         tw_im_o    <= '0;
      end else begin
         tw_valid_o <= req_valid_i;
         if (req_valid_i) begin
            tw_re_o <= nxt_re;
            tw_im_o <= nxt_im;
         end
      end
   end

   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_i |=> tw_valid_o);

   // R2
   valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid_i |=> !tw_valid_o);

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid_i |=> ($stable(tw_re_o) && $stable(tw_im_o)));

   // R6
   origin_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_idx_i == '0) |=> (tw_re_o == ONE && tw_im_o == '0));

   // R6
   quarter_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_idx_i == QUARTER) |=> (tw_re_o == '0 && tw_im_o == NEG_ONE));

   // R8
   imag_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tw_valid_o |-> (tw_im_o <= 0));

   // R8
   real_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_idx_i < QUARTER) |=> (tw_re_o >= 0));

   // R4
   mirror_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && fold.mirror) |-> (oct_addr != '0 && oct_addr < OCT_POINT));

endmodule

// File: tb/test_twiddle_gen.sv
module test_twiddle_gen;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int LOG2N = 10;
   localparam int W     = 32;
   localparam int NH    = 512;
   localparam int NQ    = 256;
   localparam int NO    = 128;
   localparam real SCALE = 1073741824.0;
   localparam real PI_R  = 3.14159265358979323846;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                req_valid_i = 1'b0;
   logic [LOG2N-2:0]    req_idx_i = '0;
   logic                tw_valid_o;
   logic signed [W-1:0] tw_re_o;
   logic signed [W-1:0] tw_im_o;

   int n_cmp  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   int got_re [NH];
   int got_im [NH];

   always #2.5 clk = ~clk;

   twiddle_gen #(.LOG2N(LOG2N), .W(W)) i_twiddle_gen (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid_i (req_valid_i),
      .req_idx_i   (req_idx_i),
      .tw_valid_o  (tw_valid_o),
      .tw_re_o     (tw_re_o),
      .tw_im_o     (tw_im_o)
   );

   function automatic int ref_q(real v);
      real s = v * SCALE;
      if (s >= 0.0) return $rtoi(s + 0.5);
      return -$rtoi(-s + 0.5);
   endfunction

   function automatic int exp_re(int k);
      return ref_q($cos(2.0 * PI_R * real'(k) / 1024.0));
   endfunction

   function automatic int exp_im(int k);
      return ref_q(-$sin(2.0 * PI_R * real'(k) / 1024.0));
   endfunction

   function automatic int iabs(int v);
      return (v < 0) ? -v : v;
   endfunction

   task automatic check_val(string req, int k, int got, int exp, int tol);
      n_cmp++;
      if (iabs(got - exp) > tol) begin
         n_fail++;
         $display("FAIL %s k=%0d actual=%0d expected=%0d", req, k, got, exp);
      end
   endtask

   task automatic check_bit(string req, logic got, logic exp);
      n_cmp++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", req, got, exp);
      end
   endtask

   function automatic string range_tag(int k);
      if (k <= NO) return "R3";
      if (k < NQ)  return "R4";
      return "R5";
   endfunction

   initial begin
      #(5ns * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
         $finish;
      end
   end

   initial begin
      int last_re;
      int last_im;
      // R1: reset state
      repeat (3) @(negedge clk);
      check_bit("R1 valid", tw_valid_o, 1'b0);
      check_val("R1 re", 0, int'(tw_re_o), 0, 0);
      check_val("R1 im", 0, int'(tw_im_o), 0, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_bit("R1 valid after release", tw_valid_o, 1'b0);
      check_val("R1 re after release", 0, int'(tw_re_o), 0, 0);

      // R9: back-to-back sweep of every index
      for (int k = 0; k < NH; k++) begin
         req_valid_i = 1'b1;
         req_idx_i   = (LOG2N-1)'(k);
         @(negedge clk);
         check_bit("R2 valid on request", tw_valid_o, 1'b1);
         got_re[k] = int'(tw_re_o);
         got_im[k] = int'(tw_im_o);
      end
      last_re = got_re[NH-1];
      last_im = got_im[NH-1];

      // R7 and R2: idle cycles with a moving index
      req_valid_i = 1'b0;
      req_idx_i   = 9'd5;
      @(negedge clk);
      check_bit("R2 valid idle", tw_valid_o, 1'b0);
      check_val("R7 hold re", 5, int'(tw_re_o), last_re, 0);
      check_val("R7 hold im", 5, int'(tw_im_o), last_im, 0);
      req_idx_i = 9'd300;
      @(negedge clk);
      check_bit("R2 valid idle", tw_valid_o, 1'b0);
      check_val("R7 hold re", 300, int'(tw_re_o), last_re, 0);
      check_val("R7 hold im", 300, int'(tw_im_o), last_im, 0);

      // R3 R4 R5: accuracy of every index
      for (int k = 0; k < NH; k++) begin
         check_val({range_tag(k), " re"}, k, got_re[k], exp_re(k), 1);
         check_val({range_tag(k), " im"}, k, got_im[k], exp_im(k), 1);
      end

      // R6: exact anchor points
      check_val("R6 origin re", 0, got_re[0], 1073741824, 0);
      check_val("R6 origin im", 0, got_im[0], 0, 0);
      check_val("R6 quarter re", NQ, got_re[NQ], 0, 0);
      check_val("R6 quarter im", NQ, got_im[NQ], -1073741824, 0);
      check_val("R6 eighth", NO, got_re[NO], -got_im[NO], 0);

      // R4: exact mirror relation
      for (int k = NO + 1; k < NQ; k++) begin
         check_val("R4 mirror re", k, got_re[k], -got_im[NQ - k], 0);
         check_val("R4 mirror im", k, got_im[k], -got_re[NQ - k], 0);
      end

      // R5: exact quarter-turn relation
      for (int k = 0; k < NQ; k++) begin
         check_val("R5 rotate re", k + NQ, got_re[k + NQ], got_im[k], 0);
         check_val("R5 rotate im", k + NQ, got_im[k + NQ], -got_re[k], 0);
      end

      // R8: signs
      for (int k = 0; k < NH; k++) begin
         n_cmp++;
         if (got_im[k] > 0 || (k < NQ && got_re[k] < 0) || (k > NQ && got_re[k] > 0)) begin
            n_fail++;
            $display("FAIL R8 sign k=%0d actual=(%0d,%0d) expected=sign rule", k, got_re[k], got_im[k]);
         end
      end

      // R9: gapped, scrambled order
      for (int j = 0; j < 60; j++) begin
         int k;
         k = (j * 37 + 11) % NH;
         req_valid_i = 1'b1;
         req_idx_i   = (LOG2N-1)'(k);
         @(negedge clk);
         check_bit("R9 valid", tw_valid_o, 1'b1);
         check_val("R9 re", k, int'(tw_re_o), exp_re(k), 1);
         check_val("R9 im", k, int'(tw_im_o), exp_im(k), 1);
         if (j % 3 == 0) begin
            req_valid_i = 1'b0;
            req_idx_i   = (LOG2N-1)'((k + 200) % NH);
            @(negedge clk);
            check_bit("R2 valid gap", tw_valid_o, 1'b0);
            check_val("R7 gap hold re", k, int'(tw_re_o), exp_re(k), 1);
         end
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   end

endmodule